// File: doc/BRIEF.md
# Frame-Boundary Shadow Register Bank

This block keeps two copies of every per-window configuration word for a display pipeline. Software writes a shadow copy. The pipeline reads only the active copy, which is presented on a flat output bus. The shadow copy of a window moves into its active copy in one step, on the cycle a vertical-sync pulse arrives. A fetch engine that starts its frame on that same pulse therefore never sees a mix of old and new settings.

Each window has a hold bit in a protect register. While the bit is set, the window is left out of the frame-boundary copy, so software can change several related fields with no risk of a partial update. Any shadow write marks its window as pending. A pending window is copied at the first sync pulse that finds it unprotected, and copying clears its pending mark. An update register holds two controls: a request bit that marks every window pending and reads back as "copies still outstanding", and a self-clearing soft-reset bit. The window enable is bit 0 of each window's control word, so turning a window off also happens only at a frame boundary.

Address map with the default `NWIN=2`, `NFIELD=9`:
- Window w, field f is at address w*9+f. The fields are 0 buffer base, 1 line pitch in pixels, 2 buffer height, 3 read offset X, 4 read offset Y, 5 top-left corner, 6 bottom-right corner, 7 alpha, 8 control.
- Address 18 is the protect register.
- Address 19 is the update register.

Top module: `vsync_shadow_bank`

## Requirements
- R1: A write to a window field (address w*NFIELD+f) changes only the shadow copy. `act_o` and `win_en_o` do not change in any cycle without `vsync_i` high.
- R2: When `vsync_i` is high at a clock edge, each pending window with a clear protect bit has all of its fields copied to `act_o` on that edge. Field f of window w occupies `act_o[(w*NFIELD+f)*DW +: DW]`.
- R3: While bit w of the protect register (address NWIN*NFIELD) is 1, window w's active fields hold through any number of sync pulses. Its shadow stays pending.
- R4: After a protect bit is written back to 0, the window's pending shadow values reach `act_o` at the next sync pulse.
- R5: `win_en_o[w]` follows bit 0 of window w's active control field (field NFIELD-1). Clearing the bit in the shadow turns the window off only at the next sync pulse.
- R6: Writing 1 to bit 0 of the update register (address NWIN*NFIELD+1) marks every window pending. Reading that register returns bit 0 = 1 while any window is pending, and 0 once all windows have been copied.
- R7: Writing 1 to bit 1 of the update register clears every shadow field, active field, protect bit and pending mark by the next edge.
- R8: `rd_data_o` returns the addressed shadow field, the protect mask or the update status one cycle after `rd_addr_i` is presented. Unmapped addresses read 0.
- R9: Windows that are unprotected and pending at the same sync pulse are all copied on that one edge.
- R10: A shadow write in the same cycle as a sync pulse is excluded from that copy, and the copy takes the earlier shadow value. The write leaves the window pending for the following pulse. A protect write in the same cycle as a pulse takes effect only from the following pulse.
- R11: The synchronous active-high `rst` clears all shadow, active, protect and read-data state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | DW | Registered read data (shadow view) |
| vsync_i | input | 1 | Frame-boundary pulse, one cycle high |
| act_o | output | NWIN*NFIELD*DW | Active fields, window-major |
| win_en_o | output | NWIN | Active window enables |

## Verification
The critical collision is a register write in the same cycle as a sync pulse. Both a shadow-field write and a protect-mask write are driven together with `vsync_i`.

For the shadow-field case, the bench first leaves an earlier value pending. It then expects the active field to show that earlier value after the collision edge, and the newly written value only after one more pulse.

For the protect case, it expects the copy to go ahead under the old mask. It then expects the window to be frozen at the pulse after that.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
  // update register bit positions
  localparam int UPD_REQ_BIT = 0;
  localparam int UPD_RST_BIT = 1;
  // enable bit inside a window control word
  localparam int CTRL_EN_BIT = 0;
endpackage

// File: rtl/vsb_window.sv
module vsb_window
  import vsb_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NFIELD = 9,
  localparam int FW    = $clog2(NFIELD)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [FW-1:0]        wr_field,
  input  logic [DW-1:0]        wr_data,
  input  logic                 vsync,
  input  logic                 protect,
  input  logic                 force_pend,
  input  logic [FW-1:0]        rd_field,
  output logic [DW-1:0]        rd_data,
  output logic [NFIELD*DW-1:0] act_o,
  output logic                 en_o,
  output logic                 pend_o
);
  logic [DW-1:0] shadow [NFIELD];
  logic [DW-1:0] active [NFIELD];
  logic          pend_q;
  logic          copy;

  assign copy = vsync && pend_q && !protect;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < NFIELD; f++) begin
        shadow[f] <= '0;
        active[f] <= '0;
      end
      pend_q <= 1'b0;
    end else begin
      if (wr_en && (int'(wr_field) < NFIELD)) shadow[wr_field] <= wr_data;
      if (copy) begin
        for (int f = 0; f < NFIELD; f++) active[f] <= shadow[f];
      end
      pend_q <= (pend_q && !copy) || wr_en || force_pend;
    end
  end

  always_comb begin
    rd_data = '0;
    if (int'(rd_field) < NFIELD) rd_data = shadow[rd_field];
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_act
    assign act_o[g*DW +: DW] = active[g];
  end

  assign en_o   = active[NFIELD-1][CTRL_EN_BIT];
  assign pend_o = pend_q;
endmodule

// File: rtl/vsb_regctl.sv
module vsb_regctl
  import vsb_pkg::*;
#(
  parameter int NWIN   = 2,
  parameter int NFIELD = 9,
  parameter int DW     = 32,
  parameter int AW     = 5,
  localparam int FW    = $clog2(NFIELD)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic [NWIN-1:0] win_we,
  output logic [FW-1:0]   wr_field,
  output logic [NWIN-1:0] prot_q,
  output logic            force_pend,
  output logic            soft_rst
);
  localparam int PROT_ADDR = NWIN * NFIELD;
  localparam int UPD_ADDR  = PROT_ADDR + 1;

  always_comb begin
    automatic int a = int'(wr_addr);
    win_we     = '0;
    wr_field   = FW'(a % NFIELD);
    soft_rst   = wr_en && (a == UPD_ADDR) && wr_data[UPD_RST_BIT];
    force_pend = wr_en && (a == UPD_ADDR) && wr_data[UPD_REQ_BIT]
                 && !wr_data[UPD_RST_BIT];
    if (wr_en && (a < PROT_ADDR)) win_we[a / NFIELD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) prot_q <= '0;
    else if (wr_en && (int'(wr_addr) == PROT_ADDR)) prot_q <= wr_data[NWIN-1:0];
  end
endmodule

// File: rtl/vsb_readmux.sv
module vsb_readmux
  import vsb_pkg::*;
#(
  parameter int NWIN   = 2,
  parameter int NFIELD = 9,
  parameter int DW     = 32,
  parameter int AW     = 5,
  localparam int FW    = $clog2(NFIELD)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [AW-1:0]      rd_addr,
  input  logic [NWIN*DW-1:0] win_rd,
  input  logic [NWIN-1:0]    prot,
  input  logic [NWIN-1:0]    pend,
  output logic [FW-1:0]      rd_field,
  output logic [DW-1:0]      rd_data_o
);
  localparam int PROT_ADDR = NWIN * NFIELD;
  localparam int UPD_ADDR  = PROT_ADDR + 1;

  logic [DW-1:0] nxt;

  always_comb begin
    automatic int a = int'(rd_addr);
    rd_field = FW'(a % NFIELD);
    nxt      = '0;
    if (a < PROT_ADDR)       nxt = win_rd[(a / NFIELD)*DW +: DW];
    else if (a == PROT_ADDR) nxt[NWIN-1:0] = prot;
    else if (a == UPD_ADDR)  nxt[UPD_REQ_BIT] = |pend;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= nxt;
  end
endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank #(
  parameter int NWIN   = 2,
  parameter int NFIELD = 9,
  parameter int DW     = 32,
  localparam int AW    = $clog2(NWIN*NFIELD + 2),
  localparam int FW    = $clog2(NFIELD)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [AW-1:0]             rd_addr_i,
  output logic [DW-1:0]             rd_data_o,
  input  logic                      vsync_i,
  output logic [NWIN*NFIELD*DW-1:0] act_o,
  output logic [NWIN-1:0]           win_en_o
);
  logic [NWIN-1:0]    win_we;
  logic [FW-1:0]      wr_field;
  logic [FW-1:0]      rd_field;
  logic [NWIN-1:0]    prot_q;
  logic [NWIN-1:0]    pend;
  logic               force_pend;
  logic               soft_rst;
  logic [NWIN*DW-1:0] win_rd;

  vsb_regctl #(.NWIN(NWIN), .NFIELD(NFIELD), .DW(DW), .AW(AW)) u_regctl (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .win_we(win_we), .wr_field(wr_field),
    .prot_q(prot_q), .force_pend(force_pend), .soft_rst(soft_rst)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    vsb_window #(.DW(DW), .NFIELD(NFIELD)) u_win (
      .clk(clk), .rst(rst || soft_rst), .wr_en(win_we[w]),
      .wr_field(wr_field), .wr_data(wr_data_i), .vsync(vsync_i),
      .protect(prot_q[w]), .force_pend(force_pend),
      .rd_field(rd_field), .rd_data(win_rd[w*DW +: DW]),
      .act_o(act_o[w*NFIELD*DW +: NFIELD*DW]), .en_o(win_en_o[w]),
      .pend_o(pend[w])
    );
  end

  vsb_readmux #(.NWIN(NWIN), .NFIELD(NFIELD), .DW(DW), .AW(AW)) u_readmux (
    .clk(clk), .rst(rst), .rd_addr(rd_addr_i), .win_rd(win_rd),
    .prot(prot_q), .pend(pend), .rd_field(rd_field), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/vsb_chk.sv
module vsb_chk #(
  parameter int NWIN   = 2,
  parameter int NFIELD = 9,
  parameter int DW     = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      vsync,
  input logic                      soft_rst,
  input logic [NWIN-1:0]           prot,
  input logic [NWIN*NFIELD*DW-1:0] act,
  input logic [NWIN-1:0]           win_en
);
  // R1
  act_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vsync && !soft_rst) |=> $stable(act));

  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!vsync && !soft_rst) |=> $stable(win_en));

  // R7
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (act == '0) && (win_en == '0));

  // R11
  hard_clear_chk: assert property (@(posedge clk)
    rst |=> (act == '0) && (win_en == '0));

  for (genvar w = 0; w < NWIN; w++) begin : g_prot
    // R3
    prot_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (vsync && prot[w] && !soft_rst) |=> $stable(act[w*NFIELD*DW +: NFIELD*DW]));
  end
endmodule

bind vsync_shadow_bank vsb_chk #(.NWIN(NWIN), .NFIELD(NFIELD), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .vsync(vsync_i), .soft_rst(soft_rst),
  .prot(prot_q), .act(act_o), .win_en(win_en_o)
);

// File: tb/vsync_shadow_bank_bench.sv
`timescale 1ns/1ps
module vsync_shadow_bank_bench;
  localparam int NWIN = 2, NFIELD = 9, DW = 32, AW = 5;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_VS = 3'd2,
                         OP_ACT = 3'd3, OP_EN = 3'd4;

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{OP_WR,  5'd0,  32'h1000, 32'h0,    8'd1},  // R1 write win0 base
    '{OP_ACT, 5'd0,  32'h0,    32'h0,    8'd1},  // R1 active untouched
    '{OP_RD,  5'd0,  32'h0,    32'h1000, 8'd8},  // R8 shadow read
    '{OP_VS,  5'd0,  32'h0,    32'h0,    8'd2},
    '{OP_ACT, 5'd0,  32'h0,    32'h1000, 8'd2},  // R2 copied
    '{OP_WR,  5'd18, 32'h1,    32'h0,    8'd3},  // R3 protect win0
    '{OP_WR,  5'd0,  32'h2000, 32'h0,    8'd3},
    '{OP_WR,  5'd9,  32'h3000, 32'h0,    8'd3},
    '{OP_VS,  5'd0,  32'h0,    32'h0,    8'd3},
    '{OP_ACT, 5'd0,  32'h0,    32'h1000, 8'd3},  // R3 frozen
    '{OP_ACT, 5'd9,  32'h0,    32'h3000, 8'd3},  // R3 other window free
    '{OP_RD,  5'd19, 32'h0,    32'h1,    8'd6},  // R6 still pending
    '{OP_RD,  5'd18, 32'h0,    32'h1,    8'd8},  // R8 protect readback
    '{OP_WR,  5'd18, 32'h0,    32'h0,    8'd4},  // R4 release
    '{OP_VS,  5'd0,  32'h0,    32'h0,    8'd4},
    '{OP_ACT, 5'd0,  32'h0,    32'h2000, 8'd4},  // R4 applied
    '{OP_RD,  5'd19, 32'h0,    32'h0,    8'd6},  // R6 all copied
    '{OP_WR,  5'd8,  32'h1,    32'h0,    8'd5},  // R5 enable win0
    '{OP_WR,  5'd17, 32'h1,    32'h0,    8'd9},  // R9 enable win1
    '{OP_EN,  5'd0,  32'h0,    32'h0,    8'd5},  // R5 not yet
    '{OP_VS,  5'd0,  32'h0,    32'h0,    8'd9},
    '{OP_EN,  5'd0,  32'h0,    32'h3,    8'd9},  // R9 both on one edge
    '{OP_WR,  5'd8,  32'h0,    32'h0,    8'd5},  // R5 disable win0
    '{OP_EN,  5'd0,  32'h0,    32'h3,    8'd5},  // R5 still on
    '{OP_VS,  5'd0,  32'h0,    32'h0,    8'd5},
    '{OP_EN,  5'd0,  32'h0,    32'h2,    8'd5},  // R5 off at frame edge
    '{OP_WR,  5'd19, 32'h1,    32'h0,    8'd6},  // R6 request
    '{OP_RD,  5'd19, 32'h0,    32'h1,    8'd6},
    '{OP_VS,  5'd0,  32'h0,    32'h0,    8'd6},
    '{OP_RD,  5'd19, 32'h0,    32'h0,    8'd6},  // R6 self-cleared
    '{OP_RD,  5'd31, 32'h0,    32'h0,    8'd8}   // R8 unmapped
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, vsync = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [NWIN*NFIELD*DW-1:0] act;
  logic [NWIN-1:0] win_en;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vsync_shadow_bank #(.NWIN(NWIN), .NFIELD(NFIELD), .DW(DW)) u_vsync_shadow_bank (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .vsync_i(vsync), .act_o(act), .win_en_o(win_en)
  );

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic vs);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; vsync = vs;
    @(negedge clk);
    wr_en = 1'b0; vsync = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    check(tag, rd_data, exp);
  endtask

  function automatic logic [DW-1:0] fld(input int idx);
    return act[idx*DW +: DW];
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    check("R11 act", DW'(|act), '0);
    check("R11 en", DW'(win_en), '0);
    rd(5'd0, '0, "R11 rd");

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = TBL[i];
      automatic string tag = $sformatf("R%0d vec%0d", v.req, i);
      case (v.op)
        OP_WR:  cyc(1'b1, v.addr, v.data, 1'b0);
        OP_VS:  cyc(1'b0, '0, '0, 1'b1);
        OP_RD:  rd(v.addr, v.exp, tag);
        OP_ACT: check(tag, fld(int'(v.addr)), v.exp);
        default: check(tag, DW'(win_en), v.exp);
      endcase
    end

    // R10 shadow write colliding with a sync pulse
    cyc(1'b1, 5'd2, 32'h55, 1'b0);
    cyc(1'b1, 5'd2, 32'h66, 1'b1);
    check("R10 old value copied", fld(2), 32'h55);
    cyc(1'b0, '0, '0, 1'b1);
    check("R10 new value next frame", fld(2), 32'h66);

    // R10 protect write colliding with a sync pulse
    cyc(1'b1, 5'd11, 32'h77, 1'b0);
    cyc(1'b1, 5'd18, 32'h2, 1'b1);
    check("R10 old mask used", fld(11), 32'h77);
    cyc(1'b1, 5'd11, 32'h88, 1'b0);
    cyc(1'b0, '0, '0, 1'b1);
    check("R10 new mask freezes", fld(11), 32'h77);

    // R7 soft reset
    cyc(1'b1, 5'd19, 32'h2, 1'b0);
    check("R7 act", DW'(|act), '0);
    check("R7 en", DW'(win_en), '0);
    rd(5'd18, '0, "R7 protect");
    rd(5'd11, '0, "R7 shadow");
    rd(5'd19, '0, "R7 pending");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule